// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block sits beside an integer adder and turns one add or subtract into the six arithmetic condition bits that later instructions test. It takes both operands, the raw sum from the adder and the adder's per-bit carry chain. It also takes a select for add or subtract and a select for an operand width of 8, 16 or 32 bits. It returns carry, overflow, sign, zero, auxiliary carry and parity, packed at fixed positions in a 16-bit status word.

The adder is expected to subtract as A + ~B + 1. The carry chain bit k is the carry out of bit position k of that addition. Every output is a pure combinational function of the present inputs. Operand and result bits above the selected width never affect a flag. The one exception is parity, which always looks at the low result byte.

Top module: `aluFlagGen`

## Requirements
- R1: Carry (status bit 0) is the carry out of the top bit of the selected width for an add, and the inverse of that carry (a borrow) for a subtract; it is 1 exactly when the unsigned result does not fit the width.
- R2: Overflow (status bit 11) is 1 when operand A and the effective second operand (B for add, the complement of B for subtract) share a sign and the result sign differs from A; this is exactly when the signed result does not fit the width.
- R3: Sign (status bit 7) equals the top bit of the result at the selected width.
- R4: Zero (status bit 6) is 1 exactly when every result bit inside the selected width is 0.
- R5: Auxiliary carry (status bit 4) is the carry out of bit 3 for an add and a borrow out of bit 3 (inverse of chain bit 3) for a subtract.
- R6: Parity (status bit 2) is 1 when result bits 7..0 hold an even number of ones, at every width.
- R7: Width select 2'b00 means 8 bits, 2'b01 means 16 bits, 2'b10 means 32 bits, and 2'b11 behaves as 32 bits; bits of A, B, result and carry chain above the selected width have no effect on any flag.
- R8: Status bits 1, 3, 5, 8, 9, 10, 12, 13, 14 and 15 always read 0.
- R9: The status word follows its inputs with no clock and no stored state; op select 0 means add, 1 means subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand as given to the instruction (not complemented) |
| result | input | 32 | Raw adder output |
| carryChain | input | 32 | Bit k is the adder carry out of bit position k |
| opSub | input | 1 | 0 for add, 1 for subtract |
| opSize | input | 2 | Operand width select |
| statusWord | output | 16 | Packed flags: CF bit 0, PF bit 2, AF bit 4, ZF bit 6, SF bit 7, OF bit 11 |

## Verification
The bench aims at width boundaries. It uses 0x7F+1, 0xFF+1, 0x80-1 and 0-1 at each size. A design that takes the sign, carry or overflow from the wrong lane would flag the 32-bit sign on a byte operation. The bench also puts noise in the operand and result bits above the width. A zero detector that scans all 32 bits would then miss a byte result of zero. Subtract vectors with and without borrow expose a carry or auxiliary carry left uninverted. Vectors whose low byte has even parity but whose upper bytes have odd parity catch a parity tree built over the wrong bits. Random vectors at every width, including the reserved width code, are compared against an arithmetic model of signed and unsigned range.

// File: rtl/aluFlagPkg.sv
package aluFlagPkg;
  localparam int DATA_W    = 32;
  localparam int STATUS_W  = 16;
  localparam int NUM_LANES = 3;

  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int OF_POS = 11;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } sizeSel_e;

  typedef struct packed {
    logic                 isSub;
    logic [NUM_LANES-1:0] laneSel;
  } flagStrobes_t;

  localparam logic [STATUS_W-1:0] FLAG_MASK =
    STATUS_W'((1 << CF_POS) | (1 << PF_POS) | (1 << AF_POS) |
              (1 << ZF_POS) | (1 << SF_POS) | (1 << OF_POS));
endpackage

// File: rtl/aluFlagCtrl.sv
module aluFlagCtrl
  import aluFlagPkg::*;
(
  input  logic         opSub,
  input  logic [1:0]   opSize,
  output flagStrobes_t strobes
);
  always_comb begin
    strobes.isSub   = opSub;
    strobes.laneSel = '0;
    unique case (sizeSel_e'(opSize))
      SZ_BYTE: strobes.laneSel[0] = 1'b1;
      SZ_HALF: strobes.laneSel[1] = 1'b1;
      SZ_WORD,
      SZ_RSVD: strobes.laneSel[2] = 1'b1;
      default: strobes.laneSel[2] = 1'b1;
    endcase
  end
endmodule

// File: rtl/aluFlagDatapath.sv
module aluFlagDatapath
  import aluFlagPkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0]    opA,
  input  logic [WIDTH-1:0]    opB,
  input  logic [WIDTH-1:0]    result,
  input  logic [WIDTH-1:0]    carryChain,
  input  flagStrobes_t        strobes,
  output logic [STATUS_W-1:0] statusWord
);
  logic [NUM_LANES-1:0] laneSignA, laneSignB, laneSignR, laneCarry, laneZero;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam int LANE_W = 8 << k;
    assign laneSignA[k] = opA[LANE_W-1];
    assign laneSignB[k] = opB[LANE_W-1];
    assign laneSignR[k] = result[LANE_W-1];
    assign laneCarry[k] = carryChain[LANE_W-1];
    assign laneZero[k]  = (result[LANE_W-1:0] == '0);
  end

  logic signA, signB, signR, carryTop, zeroSel, sameSign;
  logic cf, of, sf, zf, af, pf;

  always_comb begin
    signA    = |(laneSignA & strobes.laneSel);
    signB    = |(laneSignB & strobes.laneSel);
    signR    = |(laneSignR & strobes.laneSel);
    carryTop = |(laneCarry & strobes.laneSel);
    zeroSel  = |(laneZero  & strobes.laneSel);

    sameSign = strobes.isSub ? (signA != signB) : (signA == signB);

    cf = carryTop ^ strobes.isSub;
    af = carryChain[3] ^ strobes.isSub;
    of = sameSign && (signR != signA);
    sf = signR;
    zf = zeroSel;
    pf = ~^result[7:0];

    statusWord         = '0;
    statusWord[CF_POS] = cf;
    statusWord[PF_POS] = pf;
    statusWord[AF_POS] = af;
    statusWord[ZF_POS] = zf;
    statusWord[SF_POS] = sf;
    statusWord[OF_POS] = of;
  end
endmodule

// File: rtl/aluFlagGen.sv
module aluFlagGen
  import aluFlagPkg::*;
(
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [31:0] result,
  input  logic [31:0] carryChain,
  input  logic        opSub,
  input  logic [1:0]  opSize,
  output logic [15:0] statusWord
);
  flagStrobes_t strobes;

  aluFlagCtrl u_ctrl (
    .opSub   (opSub),
    .opSize  (opSize),
    .strobes (strobes)
  );

  aluFlagDatapath #(.WIDTH(DATA_W)) u_dp (
    .opA        (opA),
    .opB        (opB),
    .result     (result),
    .carryChain (carryChain),
    .strobes    (strobes),
    .statusWord (statusWord)
  );
endmodule

// File: rtl/aluFlagChk.sv
module aluFlagChk
  import aluFlagPkg::*;
(
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [31:0] result,
  input logic        opSub,
  input logic [1:0]  opSize,
  input logic [15:0] statusWord
);
  logic sgnA, sgnB, sgnR;
  always_comb begin
    unique case (opSize)
      2'b00:   begin sgnA = opA[7];  sgnB = opB[7];  sgnR = result[7];  end
      2'b01:   begin sgnA = opA[15]; sgnB = opB[15]; sgnR = result[15]; end
      default: begin sgnA = opA[31]; sgnB = opB[31]; sgnR = result[31]; end
    endcase
  end

  always_comb begin
    assert_reserved_zero_R8: assert ((statusWord & ~FLAG_MASK) == '0)
      else $error("reserved status bits set");
    assert_no_overflow_mixed_R2: assert (!((opSub ? (sgnA == sgnB) : (sgnA != sgnB)) && statusWord[OF_POS]))
      else $error("overflow with operands that cannot overflow");
    assert_sign_tracks_R3: assert (statusWord[SF_POS] == sgnR)
      else $error("sign flag disagrees with result top bit");
    assert_zero_sign_excl_R4: assert (!(statusWord[ZF_POS] && statusWord[SF_POS]))
      else $error("zero and sign both set");
    assert_parity_empty_R6: assert ((result[7:0] != 8'h00) || statusWord[PF_POS])
      else $error("parity clear on zero low byte");
    assert_byte_zero_R7: assert (!((opSize == 2'b00) && (result[7:0] == 8'h00)) || statusWord[ZF_POS])
      else $error("byte result zero but zero flag clear");
  end
endmodule

bind aluFlagGen aluFlagChk u_chk (
  .opA        (opA),
  .opB        (opB),
  .result     (result),
  .opSub      (opSub),
  .opSize     (opSize),
  .statusWord (statusWord)
);

// File: tb/aluFlagGen_tb.sv
module aluFlagGen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] opA = '0, opB = '0, result = '0, carryChain = '0;
  logic        opSub = 1'b0;
  logic [1:0]  opSize = 2'b00;
  logic [15:0] statusWord;

  aluFlagGen u_dut (
    .opA(opA), .opB(opB), .result(result), .carryChain(carryChain),
    .opSub(opSub), .opSize(opSize), .statusWord(statusWord)
  );

  typedef struct {
    logic [15:0] expWord;
    string       tag;
  } scoreItem_t;

  scoreItem_t sbQueue[$];
  int vecCount = 0;
  int missCount = 0;
  bit driverDone = 0;

  function automatic logic [15:0] modelFlags(input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] r, input logic sub,
                                             input logic [1:0] sz);
    int w;
    logic [31:0] mask;
    longint unsigned ua, ub;
    longint sa, sb, sres, smax, smin;
    logic [15:0] f;
    w    = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    ua   = longint'(a & mask);
    ub   = longint'(b & mask);
    sa   = (ua >= (64'd1 << (w-1))) ? longint'(ua) - (longint'(1) << w) : longint'(ua);
    sb   = (ub >= (64'd1 << (w-1))) ? longint'(ub) - (longint'(1) << w) : longint'(ub);
    smax = (longint'(1) << (w-1)) - 1;
    smin = -(longint'(1) << (w-1));
    sres = sub ? sa - sb : sa + sb;
    f = '0;
    f[0]  = sub ? (ub > ua) : ((ua + ub) > longint'(mask));
    f[11] = (sres > smax) || (sres < smin);
    f[7]  = r[w-1];
    f[6]  = ((r & mask) == 0);
    f[4]  = sub ? (b[3:0] > a[3:0]) : ((5'(a[3:0]) + 5'(b[3:0])) > 5'd15);
    f[2]  = ~^r[7:0];
    return f;
  endfunction

  task automatic applyVec(input logic [31:0] a, input logic [31:0] b,
                          input logic sub, input logic [1:0] sz, input string tag);
    logic [31:0] bb, r, cc;
    logic c;
    bb = sub ? ~b : b;
    c  = sub;
    for (int i = 0; i < 32; i++) begin
      r[i]  = a[i] ^ bb[i] ^ c;
      c     = (a[i] & bb[i]) | (a[i] & c) | (bb[i] & c);
      cc[i] = c;
    end
    @(posedge clk);
    #1;
    opA = a; opB = b; result = r; carryChain = cc; opSub = sub; opSize = sz;
    sbQueue.push_back('{modelFlags(a, b, r, sub, sz), tag});
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (sbQueue.size() > 0) begin
        scoreItem_t it;
        it = sbQueue.pop_front();
        vecCount++;
        if (statusWord !== it.expWord) begin
          missCount++;
          $display("FAIL %s: status actual %h expected %h (A=%h B=%h R=%h sub=%0d size=%0d)",
                   it.tag, statusWord, it.expWord, opA, opB, result, opSub, opSize);
        end
      end
    end
  end

  initial begin : driver
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    applyVec(32'h0, 32'h0, 1'b0, 2'b00, "R4 R6 reset-state zero add");
    applyVec(32'h7F, 32'h01, 1'b0, 2'b00, "R2 R3 R5 byte 7F+1");
    applyVec(32'hFF, 32'h01, 1'b0, 2'b00, "R1 R4 R5 byte FF+1");
    applyVec(32'h00, 32'h01, 1'b1, 2'b00, "R1 R5 byte 0-1 borrow");
    applyVec(32'h80, 32'h01, 1'b1, 2'b00, "R2 byte 80-1");
    applyVec(32'h55, 32'h11, 1'b1, 2'b00, "R1 R5 sub no borrow");
    applyVec(32'hABCD_12FF, 32'h5A5A_0001, 1'b0, 2'b00, "R7 byte upper noise zero");
    applyVec(32'h7FFF, 32'h0001, 1'b0, 2'b01, "R2 R3 half 7FFF+1");
    applyVec(32'h1234_FFFF, 32'h0000_0001, 1'b0, 2'b01, "R1 R7 half FFFF+1");
    applyVec(32'h8000, 32'h0001, 1'b1, 2'b01, "R2 half 8000-1");
    applyVec(32'hFFFF_FFFF, 32'h1, 1'b0, 2'b10, "R1 R4 word FFFFFFFF+1");
    applyVec(32'h7FFF_FFFF, 32'h1, 1'b0, 2'b10, "R2 R3 word overflow");
    applyVec(32'h0, 32'h1, 1'b1, 2'b10, "R1 R3 word 0-1");
    applyVec(32'h0101_0000, 32'h0000_0003, 1'b0, 2'b10, "R6 low byte parity only");
    applyVec(32'h0700_0000, 32'h0000_0001, 1'b0, 2'b10, "R6 odd low byte");
    applyVec(32'h7FFF_FFFF, 32'h1, 1'b0, 2'b11, "R7 reserved size as word");
    applyVec(32'h8000_0000, 32'h1, 1'b1, 2'b11, "R7 R2 reserved size sub");
    for (int sz = 0; sz < 4; sz++) begin
      for (int n = 0; n < 400; n++) begin
        applyVec($urandom, $urandom, 1'($urandom), 2'(sz), "R1 R2 R3 R4 R5 R6 R8 R9 random");
      end
    end
    @(posedge clk);
    @(negedge clk);
    driverDone = 1;
  end

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!driverDone && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    @(negedge clk);
    if (!driverDone) begin
      missCount++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule